// File: doc/BRIEF.md
# Gshare Conditional Branch Direction Predictor

This block guesses whether a conditional branch will be taken, for an in-order core that runs two hardware threads. Fetch presents a lookup with the branch PC and the thread number. One clock later the block returns a taken or not-taken guess, together with the history value that produced it. That history value is the checkpoint the core carries with the branch until the branch resolves.

When the branch resolves, the core sends an update with the thread number, the branch kind, the PC, the real direction, a misprediction flag and the checkpoint. Conditional branches train a single pattern table of 2-bit saturating counters. Both threads share this table with no partitioning. Each thread owns a 12-bit global history register. The register advances speculatively on every lookup. After a misprediction it is rebuilt from the checkpoint. Jumps, calls and returns never touch the table or the history.

Top module: `gshare_dir_pred`

## Requirements
- R1: After reset every counter holds weakly not-taken (2'b01), both histories are zero, and pred_valid is low.
- R2: pred_valid is high in exactly the cycle after a cycle with lkp_valid high. In that cycle pred_taken is the upper bit of the counter selected at lookup.
- R3: The table index is PC bits [13:2] XOR the 12-bit history of the selected thread. Updates form their index from upd_pc and upd_ckpt in the same way.
- R4: Counters use the encoding 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken. A taken update increments the counter and saturates at 3; a not-taken update decrements it and saturates at 0. A counter predicts taken when it is 2 or 3.
- R5: pred_hist returns the history in use at lookup. The lookup then shifts the predicted direction into bit 0 of that thread's history.
- R6: A lookup or a repair for one thread leaves the other thread's history unchanged.
- R7: The pattern table is shared: training done by one thread changes the predictions the other thread gets at the same index.
- R8: Updates whose upd_kind is not conditional (kind 0 is conditional; 1 jump, 2 call, 3 return) change neither the table nor any history.
- R9: A conditional update with upd_mispred high sets that thread's history to {upd_ckpt[10:0], upd_taken}. If a lookup for the same thread happens in the same cycle, this repair takes priority over the lookup's shift.
- R10: If an update and a lookup select the same counter in the same cycle, the lookup is answered with the counter value from before the update.
- R11: A conditional update without a misprediction trains the counter and leaves the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_tid | input | 1 | Thread of the lookup |
| lkp_pc | input | 32 | PC of the branch being looked up |
| pred_valid | output | 1 | Prediction available (one cycle after lookup) |
| pred_taken | output | 1 | Predicted direction |
| pred_hist | output | 12 | History used for this prediction (checkpoint) |
| upd_valid | input | 1 | Resolved branch update |
| upd_tid | input | 1 | Thread of the update |
| upd_kind | input | 2 | Branch kind: 0 conditional, 1 jump, 2 call, 3 return |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_mispred | input | 1 | The earlier prediction was wrong |
| upd_ckpt | input | 12 | Checkpoint history returned with the prediction |

## Verification
A table-driven sequence mixes lookups from both threads with a mispredicted taken update and with a jump update. This separates a per-thread history from a shared one, a shared table from a split one, and an ignored jump from one that retrains. Directed runs then apply long runs of taken and not-taken updates to a single counter, which distinguishes saturating counters from wrapping ones. A same-cycle read and write to one counter shows whether the lookup sees the old value. A lookup and a repair on the same thread in the same cycle shows which of the two wins the history register. A repair that brings in a not-taken outcome checks the appended bit.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  // Resolved branch classes; only BRK_COND trains the predictor.
  typedef enum logic [1:0] {
    BRK_COND = 2'd0,
    BRK_JUMP = 2'd1,
    BRK_CALL = 2'd2,
    BRK_RET  = 2'd3
  } br_kind_e;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_STRONG_T  = 2'b11;
endpackage

// File: rtl/gsp_index_hash.sv
module gsp_index_hash #(
  parameter int PC_W   = 32,
  parameter int PC_OFS = 2,
  parameter int HIST_W = 12
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] idx
);
  // PC bits beyond the hashed window do not take part in the index
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[PC_W-1:PC_OFS+HIST_W], pc[PC_OFS-1:0]};

  always_comb begin
    idx = pc[PC_OFS +: HIST_W] ^ hist;
  end
endmodule

// File: rtl/gsp_pattern_table.sv
module gsp_pattern_table
  import gsp_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t tbl [ENTRIES];
  ctr_t wr_cur;
  ctr_t wr_next;

  // Combinational read: a write landing on the same edge is not yet visible
  always_comb begin
    rd_ctr = tbl[rd_idx];
  end

  always_comb begin
    wr_cur  = tbl[wr_idx];
    wr_next = wr_cur;
    if (wr_taken) begin
      if (wr_cur != CTR_STRONG_T) wr_next = wr_cur + 2'd1;
    end else begin
      if (wr_cur != CTR_STRONG_NT) wr_next = wr_cur - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_next;
    end
  end

  // A taken outcome never lowers a counter, a not-taken outcome never raises one
  assert_ctr_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken |=> tbl[$past(wr_idx)] >= $past(tbl[wr_idx]));
  assert_ctr_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken |=> tbl[$past(wr_idx)] <= $past(tbl[wr_idx]));
endmodule

// File: rtl/gsp_hist_bank.sv
module gsp_hist_bank #(
  parameter int NUM_THREADS = 2,
  parameter int HIST_W      = 12,
  localparam int THR_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [THR_W-1:0]  shift_tid,
  input  logic              shift_bit,
  input  logic              repair_en,
  input  logic [THR_W-1:0]  repair_tid,
  input  logic [HIST_W-1:0] repair_val,
  output logic [HIST_W-1:0] hist_o [NUM_THREADS]
);
  logic [HIST_W-1:0] hist_q [NUM_THREADS];
  logic [HIST_W-1:0] hist_d [NUM_THREADS];
  logic              fix_hit [NUM_THREADS];
  logic              adv_hit [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_comb begin
      fix_hit[t] = repair_en && (repair_tid == THR_W'(t));
      adv_hit[t] = shift_en && (shift_tid == THR_W'(t));
      hist_d[t]  = hist_q[t];
      if (fix_hit[t]) begin
        hist_d[t] = repair_val;
      end else if (adv_hit[t]) begin
        hist_d[t] = {hist_q[t][HIST_W-2:0], shift_bit};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q[t] <= '0;
      end else if (fix_hit[t] || adv_hit[t]) begin
        hist_q[t] <= hist_d[t];
      end
    end

    assign hist_o[t] = hist_q[t];

    assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !fix_hit[t] && !adv_hit[t] |=> $stable(hist_q[t]));
    assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      adv_hit[t] && !fix_hit[t] |=> hist_q[t][HIST_W-1:1] == $past(hist_q[t][HIST_W-2:0]));
  end
endmodule

// File: rtl/gshare_dir_pred.sv
module gshare_dir_pred
  import gsp_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int HIST_W      = 12,
  parameter int PC_W        = 32,
  parameter int PC_OFS      = 2,
  localparam int THR_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [THR_W-1:0]  lkp_tid,
  input  logic [PC_W-1:0]   lkp_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [THR_W-1:0]  upd_tid,
  input  logic [1:0]        upd_kind,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic              upd_mispred,
  input  logic [HIST_W-1:0] upd_ckpt
);
  logic [HIST_W-1:0] hist_w [NUM_THREADS];
  logic [HIST_W-1:0] lkp_hist;
  logic [HIST_W-1:0] lkp_idx;
  logic [HIST_W-1:0] upd_idx;
  ctr_t              rd_ctr;
  logic              lkp_dir;
  logic              upd_cond;
  logic              repair_en;
  logic [HIST_W-1:0] repair_val;
  logic              pred_valid_d;
  logic              pred_taken_d;
  logic [HIST_W-1:0] pred_hist_d;
  logic              unused_ctr_lsb;

  always_comb begin
    lkp_hist   = hist_w[lkp_tid];
    lkp_dir    = rd_ctr[1];
    upd_cond   = upd_valid && (br_kind_e'(upd_kind) == BRK_COND);
    repair_en  = upd_cond && upd_mispred;
    repair_val = {upd_ckpt[HIST_W-2:0], upd_taken};
  end
  assign unused_ctr_lsb = rd_ctr[0];

  gsp_index_hash #(.PC_W(PC_W), .PC_OFS(PC_OFS), .HIST_W(HIST_W)) u_lkp_hash (
    .pc(lkp_pc), .hist(lkp_hist), .idx(lkp_idx)
  );

  gsp_index_hash #(.PC_W(PC_W), .PC_OFS(PC_OFS), .HIST_W(HIST_W)) u_upd_hash (
    .pc(upd_pc), .hist(upd_ckpt), .idx(upd_idx)
  );

  gsp_pattern_table #(.IDX_W(HIST_W)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lkp_idx), .rd_ctr(rd_ctr),
    .wr_en(upd_cond), .wr_idx(upd_idx), .wr_taken(upd_taken)
  );

  gsp_hist_bank #(.NUM_THREADS(NUM_THREADS), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(lkp_valid), .shift_tid(lkp_tid), .shift_bit(lkp_dir),
    .repair_en(repair_en), .repair_tid(upd_tid), .repair_val(repair_val),
    .hist_o(hist_w)
  );

  // Response stage: next-state logic
  always_comb begin
    pred_valid_d = lkp_valid;
    pred_taken_d = pred_taken;
    pred_hist_d  = pred_hist;
    if (lkp_valid) begin
      pred_taken_d = lkp_dir;
      pred_hist_d  = lkp_hist;
    end
  end

  // Response stage: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_hist  <= '0;
    end else begin
      pred_valid <= pred_valid_d;
      if (lkp_valid) begin
        pred_taken <= pred_taken_d;
        pred_hist  <= pred_hist_d;
      end
    end
  end

  assert_pred_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> pred_valid);
  assert_pred_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !pred_valid);
  assert_nocond_hist_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && (br_kind_e'(upd_kind) != BRK_COND) && !lkp_valid
      |=> hist_w[$past(upd_tid)] == $past(hist_w[upd_tid]));
  assert_ckpt_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> pred_hist == $past(hist_w[lkp_tid]));
endmodule

// File: tb/gshare_dir_pred_tb_top.sv
module gshare_dir_pred_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        lkp_valid;
  logic [0:0]  lkp_tid;
  logic [31:0] lkp_pc;
  logic        pred_valid;
  logic        pred_taken;
  logic [11:0] pred_hist;
  logic        upd_valid;
  logic [0:0]  upd_tid;
  logic [1:0]  upd_kind;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic        upd_mispred;
  logic [11:0] upd_ckpt;

  int checks = 0;
  int errors = 0;

  gshare_dir_pred dut_i (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_tid(lkp_tid), .lkp_pc(lkp_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_tid(upd_tid), .upd_kind(upd_kind),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_mispred(upd_mispred),
    .upd_ckpt(upd_ckpt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        lv;
    logic        ltid;
    logic [15:0] lpc;
    logic        uv;
    logic        utid;
    logic [1:0]  ukind;
    logic        utk;
    logic        umis;
    logic [15:0] upc;
    logic [11:0] uckpt;
    logic        epv;
    logic        ept;
    logic [11:0] eph;
  } vec_t;

  // Expected values worked out from R2, R3, R5, R7, R8 and R9 starting at reset state
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 16'h0014, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 12'h000, 1'b1, 1'b0, 12'h000},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 16'h0014, 12'h000, 1'b0, 1'b0, 12'h000},
    '{1'b1, 1'b0, 16'h0014, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 12'h000, 1'b1, 1'b0, 12'h001},
    '{1'b1, 1'b1, 16'h0014, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 12'h000, 1'b1, 1'b1, 12'h000},
    '{1'b1, 1'b1, 16'h0010, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 12'h000, 1'b1, 1'b1, 12'h001},
    '{1'b1, 1'b0, 16'h0008, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 16'h0014, 12'h000, 1'b1, 1'b0, 12'h002},
    '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 12'h000, 1'b1, 1'b0, 12'h004},
    '{1'b1, 1'b1, 16'h0018, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 12'h000, 1'b1, 1'b1, 12'h003}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lkp_valid = 1'b0; lkp_tid = '0; lkp_pc = '0;
    upd_valid = 1'b0; upd_tid = '0; upd_kind = 2'd0; upd_pc = '0;
    upd_taken = 1'b0; upd_mispred = 1'b0; upd_ckpt = '0;
  endtask

  // One cycle of stimulus; outputs are sampled 1 time unit after the edge
  task automatic step(input logic lv, input logic lt, input logic [31:0] lp,
                      input logic uv, input logic ut, input logic [1:0] uk,
                      input logic [31:0] up, input logic tk, input logic mis,
                      input logic [11:0] ck);
    lkp_valid = lv; lkp_tid = lt; lkp_pc = lp;
    upd_valid = uv; upd_tid = ut; upd_kind = uk; upd_pc = up;
    upd_taken = tk; upd_mispred = mis; upd_ckpt = ck;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic look(input logic t, input logic [31:0] pc);
    step(1'b1, t, pc, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 12'h0);
  endtask

  task automatic train(input logic t, input logic [31:0] pc, input logic tk);
    step(1'b0, 1'b0, 32'h0, 1'b1, t, 2'd0, pc, tk, 1'b0, 12'h0);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: idle output after reset
    chk("R1 pred_valid after reset", {31'h0, pred_valid}, 32'h0);

    // Vector walk
    for (int i = 0; i < 8; i++) begin
      step(VECS[i].lv, VECS[i].ltid, {16'h0, VECS[i].lpc},
           VECS[i].uv, VECS[i].utid, VECS[i].ukind, {16'h0, VECS[i].upc},
           VECS[i].utk, VECS[i].umis, VECS[i].uckpt);
      if (VECS[i].epv) begin
        chk($sformatf("R2 R3 R5 R7 R8 vector %0d", i),
            {19'h0, pred_valid, pred_taken, pred_hist},
            {19'h0, 1'b1, VECS[i].ept, VECS[i].eph});
      end else begin
        chk($sformatf("R2 vector %0d idle", i), {31'h0, pred_valid}, 32'h0);
      end
    end

    // R1: fresh counters predict not-taken with zero history
    do_reset();
    look(1'b0, 32'h0000_0040);
    chk("R1 reset counter weak not-taken", {19'h0, pred_valid, pred_taken, pred_hist}, {19'h0, 1'b1, 1'b0, 12'h000});

    // R4 and R11: saturation at the top; correct-predicted updates keep the history
    do_reset();
    for (int k = 0; k < 5; k++) train(1'b0, 32'h0000_0024, 1'b1);
    train(1'b0, 32'h0000_0024, 1'b0);
    look(1'b0, 32'h0000_0024);
    chk("R4 saturate at 3 then one decrement", {31'h0, pred_taken}, 32'h1);
    chk("R11 history untouched by correct updates", {20'h0, pred_hist}, 32'h0);
    // R4: saturation at the bottom (hist0 now 1; thread 1 history still 0)
    for (int k = 0; k < 4; k++) train(1'b1, 32'h0000_0024, 1'b0);
    train(1'b1, 32'h0000_0024, 1'b1);
    train(1'b1, 32'h0000_0024, 1'b1);
    look(1'b1, 32'h0000_0024);
    chk("R4 saturate at 0 then two increments", {19'h0, pred_valid, pred_taken, pred_hist}, {19'h0, 1'b1, 1'b1, 12'h000});

    // R10: same-cycle write and read of counter 12; hist0=1, hist1=1
    step(1'b1, 1'b0, 32'h0000_0034, 1'b1, 1'b1, 2'd0, 32'h0000_0030, 1'b1, 1'b0, 12'h000);
    chk("R10 lookup sees old counter", {31'h0, pred_taken}, 32'h0);
    look(1'b1, 32'h0000_0034);
    chk("R10 write landed after the collision", {19'h0, pred_valid, pred_taken, pred_hist}, {19'h0, 1'b1, 1'b1, 12'h001});

    // R9: repair beats same-thread lookup; hist0=2, hist1=3
    step(1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd0, 32'h0000_0100, 1'b1, 1'b1, 12'h0A5);
    chk("R9 lookup during repair reports pre-repair history", {20'h0, pred_hist}, 32'h002);
    look(1'b0, 32'h0000_0000);
    chk("R9 repair with taken outcome wins", {20'h0, pred_hist}, 32'h14B);
    look(1'b1, 32'h0000_0000);
    chk("R6 other thread history unaffected", {20'h0, pred_hist}, 32'h003);
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 2'd0, 32'h0000_0200, 1'b0, 1'b1, 12'hFFF);
    look(1'b1, 32'h0000_0000);
    chk("R9 repair with not-taken outcome", {20'h0, pred_hist}, 32'hFFE);

    // R8: call and return updates ignored by both table and history
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 2'd2, 32'h0000_0200, 1'b1, 1'b1, 12'h000);
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 2'd3, 32'h0000_0200, 1'b1, 1'b1, 12'h000);
    look(1'b1, 32'h0000_0000);
    chk("R8 call/return leave history", {20'h0, pred_hist}, 32'hFFC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule